// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block sits behind the read path of a byte-wide flash array and models what a host sees while an internal program or erase operation is running. A start pulse launches a byte program, a single-sector erase or a whole-array erase. The block then runs a cycle-count timer for the operation. While the operation runs, reads return a status byte instead of array data. When the timer expires, the small behavioural cell array is updated and a one-cycle completion pulse is raised.

The status byte has four meaningful bits:
- **Bit 7 (poll bit):** gives the inverted bit 7 of the data being programmed during a program, and 0 during an erase.
- **Bit 6 (toggle bit):** inverts on every read access while an operation is active.
- **Bit 5 (failure bit):** flags a program that tried to raise a stored 0 to 1. This condition holds until it is cleared explicitly.
- **Bit 2 (erase toggle bit):** inverts only on reads that land in sectors selected for erase.

A per-sector protect mask turns a program or erase of protected sectors into a shorter dummy run that leaves the array unchanged. A sector erase can be suspended after a fixed latency and resumed later. While it is suspended, reads outside the selected sector return array data.

All durations are parameters in clock cycles, so a simulation can scale them down.

Top module: `flash_opstat`

## Requirements
- R1: After reset the block is idle: busy_o=0, done_o=0, rd_data_o=00h. Every array byte reads FFh.
- R2: In idle, a read pulse rd_i returns the byte stored at rd_addr_i on rd_data_o one cycle later. rd_data_o holds its value between reads.
- R3: A program start in idle keeps busy_o high for PROG_CYC cycles. While it runs, status reads show bit 7 as the inverse of bit 7 of the program data. At completion done_o pulses for one cycle, busy_o falls in the same cycle, and the stored byte becomes old AND new.
- R4: While a program or erase is active, or a program has failed, each read returns a status byte. Bit 6 of that byte inverts from one read to the next at any address. Bits 4, 3, 1 and 0 of a status byte are 0.
- R5: A program whose data has a 1 where the stored byte has a 0 runs PROG_CYC cycles and then enters the failure state. In that state bit 5 reads 1, busy_o stays high, no done pulse occurs and the byte is unchanged. clear_fail_i then returns the block to idle.
- R6: A sector erase selects the sector given by op_addr_i bits [ADDR_W-1 -: log2(NUM_SECT)] and runs ERASE_CYC cycles. While it runs, bit 7 reads 0. At completion every byte of that sector reads FFh, other sectors are unchanged, and done_o pulses.
- R7: A chip erase selects all sectors and sets every byte of each unprotected sector to FFh.
- R8: Bit 2 inverts only on reads whose address lies in an erase-selected sector, both during the erase and while it is suspended. Reads elsewhere leave it unchanged.
- R9: A program into a sector whose prot_mask_i bit is set lasts PROT_PROG_CYC cycles. An erase whose selected sectors are all protected lasts PROT_ERASE_CYC cycles. Both end with done_o and no array change.
- R10: A suspend during a sector erase takes effect exactly SUSP_LAT cycles later. The erase timer is then frozen. A read in the selected sector returns 1 in bit 7, the held bit 6 and a toggling bit 2, with bit 5 at 0. Reads elsewhere return array data. Resume continues the erase, and the erase completes after ERASE_CYC active cycles in total.
- R11: The following inputs are ignored: starts while busy, suspend during a chip erase or a program, resume outside suspend, and clear_fail_i outside the failure state.
- R12: Simultaneous starts in idle are ranked as program first, then sector erase, then chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_start_i | input | 1 | Start byte program |
| sect_erase_i | input | 1 | Start sector erase |
| chip_erase_i | input | 1 | Start erase of all sectors |
| op_addr_i | input | ADDR_W | Program address / erase sector address |
| op_data_i | input | 8 | Program data |
| prot_mask_i | input | NUM_SECT | Per-sector protect mask, sampled at start |
| suspend_i | input | 1 | Suspend request |
| resume_i | input | 1 | Resume request |
| clear_fail_i | input | 1 | Leave the failure state |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Array data or status byte |
| busy_o | output | 1 | Operation in progress, suspended or failed |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with PROG_CYC=6, ERASE_CYC=20, PROT_PROG_CYC=3, PROT_ERASE_CYC=9 and SUSP_LAT=3, keeping the default 64-byte array in four sectors. These short durations allow every phase to be read repeatedly within a few dozen cycles: the toggle sequences, the exact suspend entry cycle and the completion edge. They also allow a suspend to be placed mid-erase, a resume to finish the remaining count, and a failure to be cleared, all in one short run.

// File: rtl/flash_opstat_pkg.sv
package flash_opstat_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSP,
    ST_FAIL
  } op_state_e;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_opstat_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned NUM_SECT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_we_i,
  input  logic [ADDR_W-1:0]   prog_addr_i,
  input  logic [BYTE_W-1:0]   prog_data_i,
  input  logic                erase_we_i,
  input  logic [NUM_SECT-1:0] erase_mask_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [ADDR_W-1:0]   op_addr_i,
  output logic [BYTE_W-1:0]   rd_byte_o,
  output logic [BYTE_W-1:0]   op_byte_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned SECT_W = $clog2(NUM_SECT);
  localparam int unsigned OFS_W  = ADDR_W - SECT_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      // program can only clear bits
      if (prog_we_i) mem_q[prog_addr_i] <= mem_q[prog_addr_i] & prog_data_i;
      if (erase_we_i) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (erase_mask_i[SECT_W'(i >> OFS_W)]) mem_q[i] <= '1;
        end
      end
    end
  end

  assign rd_byte_o = mem_q[rd_addr_i];
  assign op_byte_o = mem_q[op_addr_i];

  assert_single_writer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_we_i && erase_we_i));
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_opstat_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned NUM_SECT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  op_state_e           state_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [BYTE_W-1:0]   arr_byte_i,
  input  logic                prog_msb_i,
  input  logic [NUM_SECT-1:0] sel_mask_i,
  output logic [BYTE_W-1:0]   rd_data_o
);
  localparam int unsigned SECT_W = $clog2(NUM_SECT);

  logic t6_q, t2_q;
  logic in_sel, active;
  logic poll_bit, fail_bit;

  assign in_sel   = sel_mask_i[rd_addr_i[ADDR_W-1 -: SECT_W]];
  assign active   = (state_i == ST_PROG) || (state_i == ST_ERASE) || (state_i == ST_FAIL);
  assign poll_bit = (state_i == ST_ERASE) ? 1'b0 : ~prog_msb_i;
  assign fail_bit = (state_i == ST_FAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      t6_q      <= 1'b0;
      t2_q      <= 1'b0;
    end else if (rd_i) begin
      if (active) begin
        rd_data_o <= {poll_bit, t6_q, fail_bit, 2'b00, t2_q, 2'b00};
        t6_q      <= ~t6_q;
        if (in_sel) t2_q <= ~t2_q;
      end else if (state_i == ST_SUSP && in_sel) begin
        rd_data_o <= {1'b1, t6_q, 1'b0, 2'b00, t2_q, 2'b00};
        t2_q      <= ~t2_q;
      end else begin
        rd_data_o <= arr_byte_i;
      end
    end
  end

  assert_t6_frozen_susp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SUSP) |=> $stable(t6_q));
  assert_no_toggle_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |=> ($stable(t6_q) && $stable(t2_q)));
endmodule

// File: rtl/flash_opstat.sv
module flash_opstat
  import flash_opstat_pkg::*;
#(
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned NUM_SECT       = 4,
  parameter int unsigned PROG_CYC       = 350,
  parameter int unsigned ERASE_CYC      = 200000,
  parameter int unsigned PROT_PROG_CYC  = 100,
  parameter int unsigned PROT_ERASE_CYC = 5000,
  parameter int unsigned SUSP_LAT       = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_start_i,
  input  logic                sect_erase_i,
  input  logic                chip_erase_i,
  input  logic [ADDR_W-1:0]   op_addr_i,
  input  logic [7:0]          op_data_i,
  input  logic [NUM_SECT-1:0] prot_mask_i,
  input  logic                suspend_i,
  input  logic                resume_i,
  input  logic                clear_fail_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [7:0]          rd_data_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned SECT_W = $clog2(NUM_SECT);
  localparam int unsigned MAX_A  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned MAX_B  = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
  localparam int unsigned MAX_OP = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W  = $clog2(MAX_OP + 1);
  localparam int unsigned SCNT_W = $clog2(SUSP_LAT + 1);

  op_state_e             state_q;
  logic [ADDR_W-1:0]     op_addr_q;
  logic [BYTE_W-1:0]     op_data_q;
  logic [NUM_SECT-1:0]   sel_q, eff_q;
  logic                  noop_q, will_fail_q, chip_q, susp_pend_q, done_q;

  logic                  start_prog, start_sect, start_chip, start_any;
  logic [NUM_SECT-1:0]   sect_onehot, erase_sel_d, erase_eff_d;
  logic                  prog_prot, will_fail_d;
  logic [CNT_W-1:0]      tmr_load_val;
  logic                  op_expired, susp_start, susp_hit;
  logic                  prog_we, erase_we;
  logic [BYTE_W-1:0]     arr_byte, op_byte;

  assign start_prog  = (state_q == ST_IDLE) && prog_start_i;
  assign start_sect  = (state_q == ST_IDLE) && !prog_start_i && sect_erase_i;
  assign start_chip  = (state_q == ST_IDLE) && !prog_start_i && !sect_erase_i && chip_erase_i;
  assign start_any   = start_prog || start_sect || start_chip;

  assign sect_onehot = NUM_SECT'(1) << op_addr_i[ADDR_W-1 -: SECT_W];
  assign prog_prot   = prot_mask_i[op_addr_i[ADDR_W-1 -: SECT_W]];
  assign will_fail_d = |(op_data_i & ~op_byte);
  assign erase_sel_d = start_chip ? {NUM_SECT{1'b1}} : sect_onehot;
  assign erase_eff_d = erase_sel_d & ~prot_mask_i;

  always_comb begin
    if (start_prog)
      tmr_load_val = prog_prot ? CNT_W'(PROT_PROG_CYC - 1) : CNT_W'(PROG_CYC - 1);
    else
      tmr_load_val = (erase_eff_d == '0) ? CNT_W'(PROT_ERASE_CYC - 1) : CNT_W'(ERASE_CYC - 1);
  end

  flash_op_timer #(.CNT_W(CNT_W)) u_op_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_any),
    .load_val_i (tmr_load_val),
    .run_i      ((state_q == ST_PROG) || (state_q == ST_ERASE)),
    .expired_o  (op_expired)
  );

  // suspend only honoured for sector erase, one request at a time
  assign susp_start = (state_q == ST_ERASE) && !chip_q && !susp_pend_q && suspend_i && !op_expired;

  flash_op_timer #(.CNT_W(SCNT_W)) u_susp_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (susp_start),
    .load_val_i (SCNT_W'(SUSP_LAT - 1)),
    .run_i      (susp_pend_q),
    .expired_o  (susp_hit)
  );

  assign prog_we  = (state_q == ST_PROG) && op_expired && !noop_q && !will_fail_q;
  assign erase_we = (state_q == ST_ERASE) && op_expired && !noop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_addr_q   <= '0;
      op_data_q   <= '0;
      sel_q       <= '0;
      eff_q       <= '0;
      noop_q      <= 1'b0;
      will_fail_q <= 1'b0;
      chip_q      <= 1'b0;
      susp_pend_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_prog) begin
            state_q     <= ST_PROG;
            op_addr_q   <= op_addr_i;
            op_data_q   <= op_data_i;
            sel_q       <= '0;
            noop_q      <= prog_prot;
            will_fail_q <= !prog_prot && will_fail_d;
            chip_q      <= 1'b0;
          end else if (start_sect || start_chip) begin
            state_q     <= ST_ERASE;
            sel_q       <= erase_sel_d;
            eff_q       <= erase_eff_d;
            noop_q      <= (erase_eff_d == '0);
            will_fail_q <= 1'b0;
            chip_q      <= start_chip;
          end
        end
        ST_PROG: begin
          if (op_expired) begin
            if (will_fail_q) state_q <= ST_FAIL;
            else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_ERASE: begin
          if (op_expired) begin
            state_q     <= ST_IDLE;
            done_q      <= 1'b1;
            susp_pend_q <= 1'b0;
          end else if (susp_hit) begin
            state_q     <= ST_SUSP;
            susp_pend_q <= 1'b0;
          end else if (susp_start) begin
            susp_pend_q <= 1'b1;
          end
        end
        ST_SUSP: if (resume_i) state_q <= ST_ERASE;
        ST_FAIL: if (clear_fail_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  flash_cell_array #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_cells (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_we_i    (prog_we),
    .prog_addr_i  (op_addr_q),
    .prog_data_i  (op_data_q),
    .erase_we_i   (erase_we),
    .erase_mask_i (eff_q),
    .rd_addr_i    (rd_addr_i),
    .op_addr_i    (op_addr_i),
    .rd_byte_o    (arr_byte),
    .op_byte_o    (op_byte)
  );

  flash_status_mux #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state_q),
    .rd_i       (rd_i),
    .rd_addr_i  (rd_addr_i),
    .arr_byte_i (arr_byte),
    .prog_msb_i (op_data_q[7]),
    .sel_mask_i (sel_q),
    .rd_data_o  (rd_data_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  assert_done_with_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_fail_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAIL && !clear_fail_i) |=> (state_q == ST_FAIL));
  assert_no_chip_suspend_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP) |-> !chip_q);
  assert_pend_only_erase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_pend_q |-> (state_q == ST_ERASE));
endmodule

// File: tb/flash_opstat_tb.sv
module flash_opstat_tb;
  localparam int AW = 6, NS = 4;
  localparam int PC = 6, EC = 20, PP = 3, PE = 9, SL = 3;
  localparam int M_IDLE = 0, M_PROG = 1, M_ERASE = 2, M_SUSP = 3, M_FAIL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ps = 0, se = 0, ce = 0, sus = 0, res = 0, clr = 0, rd = 0;
  logic [AW-1:0] oa = '0, ra = '0;
  logic [7:0] od = '0;
  logic [NS-1:0] pm = '0;
  logic [7:0] rd_data;
  logic busy, done;

  int total = 0, bad = 0;
  bit fin = 0;
  string cur_req = "R1";

  flash_opstat #(.ADDR_W(AW), .NUM_SECT(NS), .PROG_CYC(PC), .ERASE_CYC(EC),
    .PROT_PROG_CYC(PP), .PROT_ERASE_CYC(PE), .SUSP_LAT(SL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(ps), .sect_erase_i(se), .chip_erase_i(ce),
    .op_addr_i(oa), .op_data_i(od), .prot_mask_i(pm), .suspend_i(sus), .resume_i(res),
    .clear_fail_i(clr), .rd_i(rd), .rd_addr_i(ra), .rd_data_o(rd_data), .busy_o(busy),
    .done_o(done));

  always #10 clk = ~clk;

  // reference model
  int m_st = M_IDLE, m_tmr = 0, m_stmr = 0;
  bit m_spend = 0, m_noop = 0, m_wf = 0, m_chip = 0, m_t6 = 0, m_t2 = 0;
  logic [7:0] m_mem [64];
  logic [AW-1:0] m_addr = '0;
  logic [7:0] m_data = '0;
  logic [3:0] m_sel = '0, m_eff = '0;
  logic [7:0] e_rd = '0;
  bit e_done = 0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_step();
    int st0 = m_st;
    bit act, in_sel;
    logic [3:0] selv;
    e_done = 0;
    if (rd) begin
      in_sel = m_sel[ra[5:4]];
      act = (st0 == M_PROG) || (st0 == M_ERASE) || (st0 == M_FAIL);
      if (act) begin
        e_rd = {(st0 == M_ERASE) ? 1'b0 : ~m_data[7], m_t6, st0 == M_FAIL, 2'b00, m_t2, 2'b00};
        m_t6 = ~m_t6;
        if (in_sel) m_t2 = ~m_t2;
      end else if (st0 == M_SUSP && in_sel) begin
        e_rd = {1'b1, m_t6, 1'b0, 2'b00, m_t2, 2'b00};
        m_t2 = ~m_t2;
      end else e_rd = m_mem[ra];
    end
    case (st0)
      M_IDLE: begin
        if (ps) begin
          m_st = M_PROG; m_addr = oa; m_data = od; m_sel = '0; m_chip = 0;
          m_noop = pm[oa[5:4]];
          m_wf = !m_noop && ((od & ~m_mem[oa]) != 0);
          m_tmr = m_noop ? PP - 1 : PC - 1;
        end else if (se || ce) begin
          selv = se ? (4'b1 << oa[5:4]) : 4'hF;
          m_st = M_ERASE; m_sel = selv; m_eff = selv & ~pm; m_noop = (m_eff == 0);
          m_chip = !se; m_wf = 0;
          m_tmr = m_noop ? PE - 1 : EC - 1;
        end
      end
      M_PROG: begin
        if (m_tmr == 0) begin
          if (m_noop) begin m_st = M_IDLE; e_done = 1; end
          else if (m_wf) m_st = M_FAIL;
          else begin m_mem[m_addr] = m_mem[m_addr] & m_data; m_st = M_IDLE; e_done = 1; end
        end else m_tmr--;
      end
      M_ERASE: begin
        if (m_tmr == 0) begin
          if (!m_noop)
            for (int i = 0; i < 64; i++) if (m_eff[i >> 4]) m_mem[i] = 8'hFF;
          m_st = M_IDLE; e_done = 1; m_spend = 0;
        end else begin
          m_tmr--;
          if (m_spend) begin
            if (m_stmr == 0) begin m_st = M_SUSP; m_spend = 0; end
            else m_stmr--;
          end else if (sus && !m_chip) begin
            m_spend = 1; m_stmr = SL - 1;
          end
        end
      end
      M_SUSP: if (res) m_st = M_ERASE;
      M_FAIL: if (clr) m_st = M_IDLE;
      default: ;
    endcase
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({cur_req, " rd_data"}, rd_data, e_rd);
    chk({cur_req, " busy"}, {7'd0, busy}, {7'd0, m_st != M_IDLE});
    chk({cur_req, " done"}, {7'd0, done}, {7'd0, e_done});
    ps = 0; se = 0; ce = 0; sus = 0; res = 0; clr = 0; rd = 0;
  endtask

  task automatic rd_at(logic [AW-1:0] a);
    rd = 1; ra = a; tick();
  endtask

  task automatic rd_exp(logic [AW-1:0] a, logic [7:0] exp, string req);
    rd = 1; ra = a; tick();
    chk(req, rd_data, exp);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 200 && m_st != M_IDLE; g++) rd_at(6'h2A);
  endtask

  task automatic start_prog(logic [AW-1:0] a, logic [7:0] d);
    ps = 1; oa = a; od = d; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s0;
    for (int i = 0; i < 64; i++) m_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 done", {7'd0, done}, 8'd0);
    chk("R1 rd_data", rd_data, 8'h00);
    rd_exp(6'h00, 8'hFF, "R1");
    rd_exp(6'h3F, 8'hFF, "R1");
    // R2 idle readback holds between reads
    cur_req = "R2";
    tick(); chk("R2 hold", rd_data, 8'hFF);
    // R3 program
    cur_req = "R3";
    start_prog(6'h05, 8'h3C);
    rd_exp(6'h05, 8'h80, "R3");   // ~bit7 of 3C, t6=0
    wait_idle();
    rd_exp(6'h05, 8'h3C, "R3");
    // R4 toggling during program
    cur_req = "R4";
    start_prog(6'h12, 8'hA5);
    rd_at(6'h00); s0 = rd_data;
    rd_at(6'h33);
    chk("R4 bit6 flips", rd_data & 8'h40, ~s0 & 8'h40);
    chk("R4 zero bits", rd_data & 8'h1B, 8'h00);
    wait_idle();
    rd_exp(6'h12, 8'hA5, "R4");
    // R5 failure on 0->1
    cur_req = "R5";
    start_prog(6'h05, 8'h7C);
    repeat (PC) tick();
    rd_at(6'h05);
    chk("R5 bit5", rd_data & 8'h20, 8'h20);
    chk("R5 busy held", {7'd0, busy}, 8'd1);
    repeat (3) rd_at(6'h05);
    clr = 1; tick();
    rd_exp(6'h05, 8'h3C, "R5");
    cur_req = "R11"; clr = 1; tick(); rd_exp(6'h05, 8'h3C, "R11");
    // R6 / R8 sector erase of sector 0
    cur_req = "R6";
    se = 1; oa = 6'h07; tick();
    rd_at(6'h02); chk("R6 bit7 zero", rd_data & 8'h80, 8'h00);
    cur_req = "R8";
    rd_at(6'h02); s0 = rd_data;
    rd_at(6'h03); chk("R8 bit2 in sel", rd_data & 8'h04, ~s0 & 8'h04);
    rd_at(6'h12); rd_at(6'h13); chk("R8 bit2 outside", rd_data & 8'h04, s0 & 8'h04);
    cur_req = "R6";
    wait_idle();
    rd_exp(6'h05, 8'hFF, "R6");
    rd_exp(6'h12, 8'hA5, "R6");
    // R9 protection
    cur_req = "R9";
    pm = 4'b0010;
    start_prog(6'h13, 8'h00);
    repeat (PP - 1) tick();
    chk("R9 prog busy", {7'd0, busy}, 8'd1);
    tick(); chk("R9 prog done", {7'd0, done}, 8'd1);
    rd_exp(6'h13, 8'hFF, "R9");
    se = 1; oa = 6'h10; tick();
    repeat (PE) tick();
    rd_exp(6'h12, 8'hA5, "R9");
    // R7 chip erase partial protect
    cur_req = "R7";
    start_prog(6'h30, 8'h11); wait_idle();
    ce = 1; tick(); wait_idle();
    rd_exp(6'h30, 8'hFF, "R7");
    rd_exp(6'h12, 8'hA5, "R7");
    pm = '0;
    // R10 suspend/resume on sector 2
    cur_req = "R10";
    start_prog(6'h21, 8'h0F); wait_idle();
    se = 1; oa = 6'h20; tick();
    repeat (4) rd_at(6'h21);
    sus = 1; tick();
    repeat (SL - 1) tick();
    chk("R10 not yet", {7'd0, busy}, 8'd1);
    tick();
    rd_at(6'h21); chk("R10 susp bit7", rd_data & 8'hA0, 8'h80); s0 = rd_data;
    rd_at(6'h22); chk("R10 bit6 held", rd_data & 8'h44, (s0 & 8'h40) | (~s0 & 8'h04));
    rd_exp(6'h12, 8'hA5, "R10");
    cur_req = "R11";
    sus = 1; tick(); start_prog(6'h3A, 8'h00); repeat (5) tick();
    rd_exp(6'h3A, 8'hFF, "R11");
    cur_req = "R10";
    res = 1; tick();
    wait_idle();
    rd_exp(6'h21, 8'hFF, "R10");
    // R11 chip erase ignores suspend and starts
    cur_req = "R11";
    ce = 1; tick();
    repeat (2) tick();
    sus = 1; tick(); res = 1; tick();
    repeat (SL + 2) tick();
    rd_at(6'h10); chk("R11 still erasing", rd_data & 8'h80, 8'h00);
    start_prog(6'h12, 8'h00);
    wait_idle();
    rd_exp(6'h12, 8'hFF, "R11");
    // R12 priorities
    cur_req = "R12";
    ps = 1; se = 1; oa = 6'h08; od = 8'hF0; tick(); wait_idle();
    rd_exp(6'h08, 8'hF0, "R12");
    start_prog(6'h38, 8'h00); wait_idle();
    se = 1; ce = 1; oa = 6'h08; tick(); wait_idle();
    rd_exp(6'h08, 8'hFF, "R12");
    rd_exp(6'h38, 8'h00, "R12");
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule